// File: doc/BRIEF.md
# DDR2 Burst-Interruption Protocol Monitor

This block is a passive, synthesizable monitor for a DDR2 SDRAM command bus. It receives one decoded command per clock, with its bank address, and the current mode settings: a burst-length-8 select, additive latency, write latency and write recovery. It reports in the same cycle whether that command breaks the burst-interruption rules or the precharge spacing rules. A legal interruption is marked with its own flag.

Two pieces of state are kept. The first is the column burst in flight: its direction, whether it auto-precharges, and how many clocks have passed since it was issued. The second is one down-counter per bank that holds the earliest clock at which a precharge to that bank is legal. Precharge spacing always uses the full burst length from the mode settings, so an interrupted burst does not shorten it.

Command encoding on `cmd_i`: 0 no-op, 1 read, 2 read with auto-precharge, 3 write, 4 write with auto-precharge, 5 precharge. Codes 6 and 7 are treated as no-op. Error codes on `err_code_o`: 0 none, 1 wrong command class, 2 interrupt while burst length is 4, 3 wrong interrupt offset, 4 interrupt of an auto-precharge burst, 5 early precharge. When several faults apply, the first in this order is reported: 4, 2, 1, 3, 5.

Top module: `ddr_bi_checker`

## Requirements
- R1: With `bl8_i`=0, a read or write issued fewer than 2 clocks after the previous column command gives error code 2. One issued exactly 2 clocks after gives no error.
- R2: With `bl8_i`=1, a write, write with auto-precharge, or precharge issued inside the 4-clock window of a read burst gives error code 1.
- R3: With `bl8_i`=1, a read, read with auto-precharge, or precharge issued inside the 4-clock window of a write burst gives error code 1.
- R4: With `bl8_i`=1, a same-direction column command issued exactly 2 clocks after the previous column command raises `intr_ok_o` with no error. Offsets 1 or 3 give error code 3.
- R5: The bank of an interrupting command has no effect on whether the interruption is legal.
- R6: Any column command or precharge inside the window of a burst started with auto-precharge gives error code 4.
- R7: A precharge to a bank fewer than AL + BL/2 clocks after a read to that bank gives error code 5. BL is 8 when `bl8_i`=1, otherwise 4. This holds even when the read was interrupted. At exactly that spacing there is no error.
- R8: A precharge to a bank fewer than WL + BL/2 + tWR clocks after a write to that bank gives error code 5. At exactly that spacing there is no error.
- R9: A column command issued BL/2 or more clocks after the previous column command gives neither an error nor `intr_ok_o`.
- R10: A later column command to a bank never shortens that bank's pending precharge wait. Its counter keeps the larger of the two requirements.
- R11: `err_o` is high only in the cycle of an offending command, and `err_code_o` is 0 whenever `err_o` is low.
- R12: While `rst` is high the outputs are 0. Synchronous reset clears all burst and bank state, so a command in the first cycle after reset raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Decoded command for this cycle |
| bank_i | input | BANK_W | Bank address of the command |
| bl8_i | input | 1 | Mode setting: 1 for burst length 8, 0 for burst length 4 |
| al_i | input | LAT_W | Additive latency in clocks |
| wl_i | input | LAT_W | Write latency in clocks |
| twr_i | input | LAT_W | Write recovery in clocks |
| err_o | output | 1 | The command in this cycle is illegal |
| err_code_o | output | 3 | Class of the violation, 0 when there is none |
| intr_ok_o | output | 1 | The command in this cycle is a legal interruption |

## Verification
The embedded assertions check on every cycle the following: an interruption is flagged only two clocks after a column command, an auto-precharge burst rejects a column command one clock later, burst-length-4 back-to-back reads one clock apart are rejected, a precharge right after a read to the same bank is rejected, the bank counters decay, and the outputs stay quiet when reset is released. Only the bench's scenarios can show the exact precharge boundaries. These are the spacing of AL + BL/2 after an interrupted read, and the write recovery spacing. The scenarios also show that the larger of two overlapping bank requirements is kept, and how the error priority resolves across mixed command sequences.

// File: rtl/ddr_bi_pkg.sv
package ddr_bi_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_RD   = 3'd1,
        CMD_RDA  = 3'd2,
        CMD_WR   = 3'd3,
        CMD_WRA  = 3'd4,
        CMD_PRE  = 3'd5,
        CMD_RSV6 = 3'd6,
        CMD_RSV7 = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_CLASS     = 3'd1,
        ERR_BL4       = 3'd2,
        ERR_OFFSET    = 3'd3,
        ERR_AUTOPRE   = 3'd4,
        ERR_EARLY_PRE = 3'd5
    } err_e;

    localparam int MAX_HALF    = 4;   // BL/2 for burst length 8
    localparam int MIN_HALF    = 2;   // BL/2 for burst length 4
    localparam int INTR_OFFSET = 2;   // only legal interrupt spacing
    localparam int AGE_W       = $clog2(MAX_HALF + 1);

    typedef struct packed {
        logic             wr;
        logic             ap;
        logic [AGE_W-1:0] age;
    } burst_s;

    function automatic logic is_col(cmd_e c);
        return (c == CMD_RD) || (c == CMD_RDA) || (c == CMD_WR) || (c == CMD_WRA);
    endfunction

    function automatic logic is_wr(cmd_e c);
        return (c == CMD_WR) || (c == CMD_WRA);
    endfunction

    function automatic logic is_ap(cmd_e c);
        return (c == CMD_RDA) || (c == CMD_WRA);
    endfunction

endpackage

// File: rtl/ddr_bi_burst_track.sv
module ddr_bi_burst_track
    import ddr_bi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_e cmd,
    input  logic bl8,
    output err_e win_code,
    output logic intr_ok
);

    burst_s           st;
    logic [AGE_W-1:0] half;
    logic             in_win;

    assign half   = bl8 ? AGE_W'(MAX_HALF) : AGE_W'(MIN_HALF);
    assign in_win = st.age < half;

    always_comb begin
        win_code = ERR_NONE;
        intr_ok  = 1'b0;
        if (in_win && (is_col(cmd) || cmd == CMD_PRE)) begin
            if (st.ap)
                win_code = ERR_AUTOPRE;
            else if (cmd == CMD_PRE)
                win_code = bl8 ? ERR_CLASS : ERR_NONE;
            else if (!bl8)
                win_code = ERR_BL4;
            else if (is_wr(cmd) != st.wr)
                win_code = ERR_CLASS;
            else if (st.age != AGE_W'(INTR_OFFSET))
                win_code = ERR_OFFSET;
            else
                intr_ok = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{wr: 1'b0, ap: 1'b0, age: AGE_W'(MAX_HALF)};
        end else if (is_col(cmd)) begin
            st <= '{wr: is_wr(cmd), ap: is_ap(cmd), age: AGE_W'(1)};
        end else if (st.age < AGE_W'(MAX_HALF)) begin
            st.age <= st.age + AGE_W'(1);
        end
    end

    // R4: a legal interruption is always two clocks after a column command
    p_intr_two_after_r4: assert property (@(posedge clk) disable iff (rst)
        intr_ok |-> $past(is_col(cmd), 2));

    // R6: an auto-precharge burst rejects a column command one clock later
    p_ap_block_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(is_ap(cmd)) && is_col(cmd)) |-> win_code == ERR_AUTOPRE);

endmodule

// File: rtl/ddr_bi_bank_timer.sv
module ddr_bi_bank_timer
    import ddr_bi_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int LAT_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic              bl8,
    input  logic [LAT_W-1:0]  al,
    input  logic [LAT_W-1:0]  wl,
    input  logic [LAT_W-1:0]  twr,
    output logic              early_pre
);

    localparam int CNT_W = LAT_W + 2;

    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] rd_req;
    logic [CNT_W-1:0] wr_req;
    logic [CNT_W-1:0] new_req;
    logic [CNT_W-1:0] cnt [NUM_BANKS];

    assign half    = bl8 ? CNT_W'(MAX_HALF) : CNT_W'(MIN_HALF);
    assign rd_req  = CNT_W'(al) + half;
    assign wr_req  = CNT_W'(wl) + half + CNT_W'(twr);
    assign new_req = (is_wr(cmd) ? wr_req : rd_req) - CNT_W'(1);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [CNT_W-1:0] dec;
        logic             hit;

        assign dec = (cnt[b] == '0) ? '0 : cnt[b] - CNT_W'(1);
        assign hit = is_col(cmd) && (bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (rst)
                cnt[b] <= '0;
            else if (hit)
                cnt[b] <= (new_req > dec) ? new_req : dec;
            else
                cnt[b] <= dec;
        end

        // R10: without a new column command the wait only counts down by one
        p_cnt_decay_r10: assert property (@(posedge clk) disable iff (rst)
            (!hit && cnt[b] != '0) |=> cnt[b] == $past(cnt[b]) - CNT_W'(1));
    end

    assign early_pre = (cmd == CMD_PRE) && (cnt[bank] != '0);

endmodule

// File: rtl/ddr_bi_checker.sv
module ddr_bi_checker
    import ddr_bi_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = $clog2(NUM_BANKS),
    parameter int LAT_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              bl8_i,
    input  logic [LAT_W-1:0]  al_i,
    input  logic [LAT_W-1:0]  wl_i,
    input  logic [LAT_W-1:0]  twr_i,
    output logic              err_o,
    output logic [2:0]        err_code_o,
    output logic              intr_ok_o
);

    cmd_e cmd;
    err_e win_code;
    err_e code;
    logic win_ok;
    logic early_pre;

    assign cmd = cmd_e'(cmd_i);

    ddr_bi_burst_track u_track (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .bl8      (bl8_i),
        .win_code (win_code),
        .intr_ok  (win_ok)
    );

    ddr_bi_bank_timer #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .LAT_W     (LAT_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .bank      (bank_i),
        .bl8       (bl8_i),
        .al        (al_i),
        .wl        (wl_i),
        .twr       (twr_i),
        .early_pre (early_pre)
    );

    always_comb begin
        if (rst)
            code = ERR_NONE;
        else if (win_code != ERR_NONE)
            code = win_code;
        else if (early_pre)
            code = ERR_EARLY_PRE;
        else
            code = ERR_NONE;
    end

    assign err_code_o = code;
    assign err_o      = (code != ERR_NONE);
    assign intr_ok_o  = !rst && win_ok;

    // R1: with burst length 4, reads one clock apart are rejected
    p_bl4_block_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !bl8_i && $past(cmd_i) == 3'd1 && cmd_i == 3'd1)
            |-> err_code_o == 3'd2);

    // R7: with burst length 4, a precharge right after a read to its bank is early
    p_pre_after_read_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !bl8_i && $past(cmd_i) == 3'd1 && cmd_i == 3'd5
            && $past(bank_i) == bank_i) |-> err_code_o == 3'd5);

    // R12: no error in the first cycle after reset is released
    p_reset_quiet_r12: assert property (@(posedge clk)
        $fell(rst) |-> !err_o);

endmodule

// File: tb/ddr_bi_checker_tb.sv
module ddr_bi_checker_tb;

    localparam logic [2:0] NOP = 3'd0, RD = 3'd1, RDA = 3'd2, WR = 3'd3, PRE = 3'd5;

    typedef struct packed {
        logic       rst;
        logic       bl8;
        logic [2:0] cmd;
        logic [1:0] bank;
        logic [2:0] code;
        logic       ok;
        logic [3:0] req;
    } vec_t;

    // al=0, wl=2, twr=2 for the whole table
    localparam int NV = 41;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd12}, // 0  R12 reset
        '{1'b1, 1'b1, RD,  2'd0, 3'd0, 1'b0, 4'd12}, // 1  R12 gated
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd12}, // 2
        '{1'b0, 1'b1, RD,  2'd0, 3'd0, 1'b0, 4'd9},  // 3
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd9},  // 4
        '{1'b0, 1'b1, RD,  2'd1, 3'd0, 1'b1, 4'd5},  // 5  R4 R5 other bank
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd9},  // 6
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd9},  // 7
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd9},  // 8
        '{1'b0, 1'b1, RD,  2'd1, 3'd0, 1'b0, 4'd9},  // 9  R9 offset 4
        '{1'b0, 1'b1, WR,  2'd0, 3'd1, 1'b0, 4'd2},  // 10 R2
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd11}, // 11 R11
        '{1'b0, 1'b1, RD,  2'd2, 3'd1, 1'b0, 4'd3},  // 12 R3
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd11}, // 13
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd11}, // 14
        '{1'b0, 1'b1, RD,  2'd3, 3'd3, 1'b0, 4'd4},  // 15 R4 offset 3
        '{1'b0, 1'b1, RDA, 2'd2, 3'd3, 1'b0, 4'd4},  // 16 R4 offset 1
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd11}, // 17
        '{1'b0, 1'b1, RD,  2'd3, 3'd4, 1'b0, 4'd6},  // 18 R6
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd11}, // 19
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd11}, // 20
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd11}, // 21
        '{1'b0, 1'b1, PRE, 2'd3, 3'd0, 1'b0, 4'd7},  // 22 R7 exact spacing
        '{1'b0, 1'b1, WR,  2'd1, 3'd0, 1'b0, 4'd9},  // 23
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd11}, // 24
        '{1'b0, 1'b1, WR,  2'd1, 3'd0, 1'b1, 4'd4},  // 25 R4 write
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd11}, // 26
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd11}, // 27
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd11}, // 28
        '{1'b0, 1'b1, PRE, 2'd1, 3'd5, 1'b0, 4'd8},  // 29 R8
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd11}, // 30
        '{1'b0, 1'b1, NOP, 2'd0, 3'd0, 1'b0, 4'd11}, // 31
        '{1'b0, 1'b1, PRE, 2'd1, 3'd5, 1'b0, 4'd8},  // 32 R8 one short
        '{1'b0, 1'b1, PRE, 2'd1, 3'd0, 1'b0, 4'd8},  // 33 R8 exact
        '{1'b0, 1'b0, RD,  2'd2, 3'd0, 1'b0, 4'd9},  // 34
        '{1'b0, 1'b0, RD,  2'd2, 3'd2, 1'b0, 4'd1},  // 35 R1
        '{1'b0, 1'b0, NOP, 2'd0, 3'd0, 1'b0, 4'd11}, // 36
        '{1'b0, 1'b0, RD,  2'd3, 3'd0, 1'b0, 4'd1},  // 37 R1 R9 offset 2
        '{1'b0, 1'b0, WR,  2'd3, 3'd2, 1'b0, 4'd1},  // 38 R1
        '{1'b0, 1'b0, PRE, 2'd3, 3'd5, 1'b0, 4'd8},  // 39 R8 BL4
        '{1'b0, 1'b0, NOP, 2'd0, 3'd0, 1'b0, 4'd11}  // 40
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cmd_i = 3'd0;
    logic [1:0] bank_i = 2'd0;
    logic       bl8_i = 1'b1;
    logic [3:0] al_i = 4'd0;
    logic [3:0] wl_i = 4'd2;
    logic [3:0] twr_i = 4'd2;
    logic       err_o;
    logic [2:0] err_code_o;
    logic       intr_ok_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ddr_bi_checker u_dut (
        .clk        (clk),
        .rst        (rst),
        .cmd_i      (cmd_i),
        .bank_i     (bank_i),
        .bl8_i      (bl8_i),
        .al_i       (al_i),
        .wl_i       (wl_i),
        .twr_i      (twr_i),
        .err_o      (err_o),
        .err_code_o (err_code_o),
        .intr_ok_o  (intr_ok_o)
    );

    task automatic step(input logic r, input logic b8, input logic [2:0] c, input logic [1:0] bk);
        @(negedge clk);
        rst = r; bl8_i = b8; cmd_i = c; bank_i = bk;
        #1;
    endtask

    task automatic chk(input logic [2:0] code, input logic ok, input string tag);
        checks++;
        if (err_o !== (code != 3'd0) || err_code_o !== code || intr_ok_o !== ok) begin
            errors++;
            $display("FAIL %s: err=%0b code=%0d ok=%0b, expected err=%0b code=%0d ok=%0b",
                     tag, err_o, err_code_o, intr_ok_o, code != 3'd0, code, ok);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NV; i++) begin
            step(TBL[i].rst, TBL[i].bl8, TBL[i].cmd, TBL[i].bank);
            chk(TBL[i].code, TBL[i].ok, $sformatf("R%0d row %0d", TBL[i].req, i));
        end

        // R7: interrupted read still needs AL + 4 clocks before precharge (AL=3)
        al_i = 4'd3; wl_i = 4'd2; twr_i = 4'd2;
        step(1, 1, NOP, 0); step(1, 1, NOP, 0);
        step(0, 1, RD, 0);  chk(3'd0, 1'b0, "R7 first read");
        step(0, 1, NOP, 0);
        step(0, 1, RD, 1);  chk(3'd0, 1'b1, "R7 interrupt");
        step(0, 1, NOP, 0); step(0, 1, NOP, 0); step(0, 1, NOP, 0);
        step(0, 1, PRE, 0); chk(3'd5, 1'b0, "R7 early after interrupt");
        step(0, 1, PRE, 0); chk(3'd0, 1'b0, "R7 full spacing");

        // R10: a later read does not shorten a pending write wait (tWR=4)
        al_i = 4'd0; twr_i = 4'd4;
        step(1, 1, NOP, 0);
        step(0, 1, WR, 2);
        for (int k = 0; k < 3; k++) step(0, 1, NOP, 0);
        step(0, 1, RD, 2);  chk(3'd0, 1'b0, "R10 read after write");
        for (int k = 0; k < 4; k++) step(0, 1, NOP, 0);
        step(0, 1, PRE, 2); chk(3'd5, 1'b0, "R10 still waiting");
        step(0, 1, PRE, 2); chk(3'd0, 1'b0, "R10 released");

        // R11: the error lasts only for the offending command
        step(0, 1, WR, 1);  chk(3'd0, 1'b0, "R11 write");
        step(0, 1, RD, 1);  chk(3'd1, 1'b0, "R11 bad read");
        step(0, 1, NOP, 0); chk(3'd0, 1'b0, "R11 next cycle");

        // R12: reset inside an auto-precharge burst clears tracking
        for (int k = 0; k < 4; k++) step(0, 1, NOP, 0);
        step(0, 1, RDA, 0);
        step(1, 1, NOP, 0); chk(3'd0, 1'b0, "R12 in reset");
        step(0, 1, RD, 0);  chk(3'd0, 1'b0, "R12 after release");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule